// File: doc/BRIEF.md
# Performance Event Counter Bank

This block is a bank of six 32-bit event counters that a processor core uses to profile its own execution. Each counter watches one event line selected from a parameterised event bus and adds one for every cycle that the line is high. Counting can be stopped in several ways. A bank-wide freeze stops every counter. A per-counter freeze stops one counter. Two privilege qualifiers and two mark qualifiers stop a counter according to the core's current privilege level and mark bit.

Software reaches every register through a small port: a 4-bit address, a write strobe, 32-bit write data, and read data that is registered one cycle after the address. To sample every N events, software preloads a counter with 0x80000000 minus N. When bit 31 of a counter becomes 1 and that counter has its condition enable set, the counter is overflowed. An overflowed counter raises a level interrupt if interrupts are enabled. If freeze-on-overflow is enabled, it also stops the whole bank.

The bank-wide freeze is held by a three-state controller. BANK_FROZEN is entered at reset and whenever software writes the freeze bit as 1. BANK_RUN is entered from any state when software writes the freeze bit as 0. BANK_OVF_HALT is entered from BANK_RUN when freeze-on-overflow is set, an enabled counter is overflowed, and no global write occurs in that cycle. A global write moves BANK_OVF_HALT to BANK_RUN or BANK_FROZEN according to the written freeze bit. The freeze bit reads as 1 in BANK_FROZEN and in BANK_OVF_HALT.

Top module: `pmu_counter_unit`

## Requirements
- R1: After reset, the global register reads 0x1 (frozen, with interrupt and freeze-on-overflow off), every counter reads 0, every counter control register reads 0x1F (all five freeze bits set, condition enable clear, select 0), and ovf_irq is low.
- R2: Register map, with read data valid on the cycle after the address: address 0 is the global register, with bit 0 freeze-all, bit 1 interrupt enable and bit 2 freeze-on-overflow. Address 1+i is counter i. Address 8+i is control for counter i, with bit 0 counter freeze, bit 1 freeze when cpu_user=0, bit 2 freeze when cpu_user=1, bit 3 freeze when cpu_mark=1, bit 4 freeze when cpu_mark=0, bit 5 condition enable, and bits 15:8 event select. Unused bits and addresses read 0, and writes to unused addresses have no effect.
- R3: An unfrozen counter adds exactly one for each clock edge at which its selected event line is high.
- R4: A counter ignores event lines other than its selected one, and a select value of NUM_EVT or more never counts.
- R5: While the global freeze bit is set, no counter changes except by a register write.
- R6: A counter whose own freeze bit is set does not count, while other counters continue.
- R7: A counter does not count in a privilege level whose freeze bit is set (cpu_user=1 is user, 0 is supervisor).
- R8: A counter does not count while the mark bit is in a state whose freeze bit is set.
- R9: A register write to a counter in the same cycle as an increment loads the written value without the increment.
- R10: ovf_irq is high exactly while interrupt enable is set and some counter has bit 31 set and condition enable set. It falls once software rewrites that counter with bit 31 clear, or clears interrupt enable.
- R11: With freeze-on-overflow set, an enabled overflow stops every counter from the cycle in which it becomes visible, and the freeze bit reads 1 until software writes it as 0.
- R12: A counter with condition enable clear neither raises ovf_irq nor freezes the bank when its bit 31 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, one cycle after the address |
| evt_in | input | NUM_EVT (16) | Event lines, each counted per cycle while high |
| cpu_user | input | 1 | Current privilege: 1 user, 0 supervisor |
| cpu_mark | input | 1 | Current processor mark bit |
| ovf_irq | output | 1 | Level overflow interrupt request |

## Verification
The hardest situation to reach from the ports is the automatic bank freeze. It needs a counter sitting one event below bit 31, with condition enable and freeze-on-overflow both set, and with a second counter counting the same event, so that the test can see that both stop in the cycle the overflow appears. The stimulus reaches it by preloading 0x7FFFFFFF through the register port while the bank is frozen. It then releases the bank and holds the event high for several cycles. After that it reads back both counters and the global freeze bit. Every count is checked to the exact cycle, by driving events for a known number of edges.

// File: rtl/pmu_pkg.sv
package pmu_pkg;

    typedef enum logic [1:0] {
        BANK_FROZEN   = 2'd0,
        BANK_RUN      = 2'd1,
        BANK_OVF_HALT = 2'd2
    } bank_state_e;

    // global register bit positions
    localparam int GLB_FRZ        = 0;
    localparam int GLB_IRQ_EN     = 1;
    localparam int GLB_FRZ_ON_OVF = 2;
    localparam int GLB_BITS       = 3;

    // per-counter control bit positions
    localparam int CTL_FRZ_CTR  = 0;
    localparam int CTL_FRZ_SUP  = 1;
    localparam int CTL_FRZ_USER = 2;
    localparam int CTL_FRZ_MSET = 3;
    localparam int CTL_FRZ_MCLR = 4;
    localparam int CTL_COND_EN  = 5;
    localparam int CTL_SEL_LSB  = 8;

    // address layout
    localparam int GLB_ADDR = 0;
    localparam int CNT_BASE = 1;
    localparam int CTL_BASE = 8;

endpackage

// File: rtl/pmu_bank_ctrl.sv
module pmu_bank_ctrl
    import pmu_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                glb_wr,
    input  logic [GLB_BITS-1:0] glb_wdata,
    input  logic                ovf_any,
    output logic                count_stop,
    output logic                ovf_irq,
    output logic [GLB_BITS-1:0] glb_rd
);

    bank_state_e state_q, state_d;
    logic        irq_en_q;
    logic        frz_ovf_q;
    logic        freeze_all;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BANK_FROZEN: begin
                if (glb_wr && !glb_wdata[GLB_FRZ])
                    state_d = BANK_RUN;
            end
            BANK_RUN: begin
                if (glb_wr)
                    state_d = glb_wdata[GLB_FRZ] ? BANK_FROZEN : BANK_RUN;
                else if (frz_ovf_q && ovf_any)
                    state_d = BANK_OVF_HALT;
            end
            BANK_OVF_HALT: begin
                if (glb_wr)
                    state_d = glb_wdata[GLB_FRZ] ? BANK_FROZEN : BANK_RUN;
            end
            default: state_d = BANK_FROZEN;
        endcase
    end

    // state register and global control bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= BANK_FROZEN;
            irq_en_q  <= 1'b0;
            frz_ovf_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (glb_wr) begin
                irq_en_q  <= glb_wdata[GLB_IRQ_EN];
                frz_ovf_q <= glb_wdata[GLB_FRZ_ON_OVF];
            end
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            BANK_RUN:      freeze_all = 1'b0;
            BANK_FROZEN:   freeze_all = 1'b1;
            BANK_OVF_HALT: freeze_all = 1'b1;
            default:       freeze_all = 1'b1;
        endcase
        count_stop = freeze_all || (frz_ovf_q && ovf_any);
        ovf_irq    = irq_en_q && ovf_any;
        glb_rd                 = '0;
        glb_rd[GLB_FRZ]        = freeze_all;
        glb_rd[GLB_IRQ_EN]     = irq_en_q;
        glb_rd[GLB_FRZ_ON_OVF] = frz_ovf_q;
    end

    // R11: an enabled overflow in run state halts the bank on the next edge
    a_r11_auto_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BANK_RUN && frz_ovf_q && ovf_any && !glb_wr)
            |=> (state_q == BANK_OVF_HALT));

    // R11: the overflow halt is left only through a global write
    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BANK_OVF_HALT && !glb_wr) |=> (state_q == BANK_OVF_HALT));

endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
    import pmu_pkg::*;
#(
    parameter int CNT_W   = 32,
    parameter int SEL_W   = 8,
    parameter int NUM_EVT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               count_stop,
    input  logic               cpu_user,
    input  logic               cpu_mark,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               wr_cnt,
    input  logic               wr_ctl,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   cnt_q,
    output logic [CNT_W-1:0]   ctl_rd,
    output logic               ovf_cond
);

    localparam int               EVT_SPACE = 2 ** SEL_W;
    localparam logic [SEL_W:0]   EVT_LIMIT = (SEL_W + 1)'(NUM_EVT);

    logic             frz_ctr_q, frz_sup_q, frz_user_q, frz_mset_q, frz_mclr_q;
    logic             cond_en_q;
    logic [SEL_W-1:0] sel_q;

    logic [EVT_SPACE-1:0] evt_pad;
    logic                 evt_hit;
    logic                 priv_frz, mark_frz, cnt_en;

    always_comb begin
        evt_pad  = EVT_SPACE'(evt_in);
        evt_hit  = evt_pad[sel_q];
        priv_frz = cpu_user ? frz_user_q : frz_sup_q;
        mark_frz = cpu_mark ? frz_mset_q : frz_mclr_q;
        cnt_en   = evt_hit && !count_stop && !frz_ctr_q && !priv_frz && !mark_frz;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            frz_ctr_q  <= 1'b1;
            frz_sup_q  <= 1'b1;
            frz_user_q <= 1'b1;
            frz_mset_q <= 1'b1;
            frz_mclr_q <= 1'b1;
            cond_en_q  <= 1'b0;
            sel_q      <= '0;
        end else begin
            if (wr_cnt)
                cnt_q <= wdata;
            else if (cnt_en)
                cnt_q <= cnt_q + 1'b1;
            if (wr_ctl) begin
                frz_ctr_q  <= wdata[CTL_FRZ_CTR];
                frz_sup_q  <= wdata[CTL_FRZ_SUP];
                frz_user_q <= wdata[CTL_FRZ_USER];
                frz_mset_q <= wdata[CTL_FRZ_MSET];
                frz_mclr_q <= wdata[CTL_FRZ_MCLR];
                cond_en_q  <= wdata[CTL_COND_EN];
                sel_q      <= wdata[CTL_SEL_LSB +: SEL_W];
            end
        end
    end

    always_comb begin
        ctl_rd                         = '0;
        ctl_rd[CTL_FRZ_CTR]            = frz_ctr_q;
        ctl_rd[CTL_FRZ_SUP]            = frz_sup_q;
        ctl_rd[CTL_FRZ_USER]           = frz_user_q;
        ctl_rd[CTL_FRZ_MSET]           = frz_mset_q;
        ctl_rd[CTL_FRZ_MCLR]           = frz_mclr_q;
        ctl_rd[CTL_COND_EN]            = cond_en_q;
        ctl_rd[CTL_SEL_LSB +: SEL_W]   = sel_q;
        ovf_cond                       = cnt_q[CNT_W-1] && cond_en_q;
    end

    // R5: a stopped bank holds every counter unless software writes it
    a_r5_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (count_stop && !wr_cnt) |=> $stable(cnt_q));

    // R9: a counter write lands exactly, whatever the event does
    a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(wdata)));

    // R4: a select beyond the event bus never advances the counter
    a_r4_unmapped_select: assert property (@(posedge clk) disable iff (!rst_n)
        (({1'b0, sel_q} >= EVT_LIMIT) && !wr_cnt) |=> $stable(cnt_q));

    // R7: user level with user freeze set holds the counter
    a_r7_user_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_user && frz_user_q && !wr_cnt) |=> $stable(cnt_q));

    // R6: counter freeze bit holds the counter
    a_r6_own_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (frz_ctr_q && !wr_cnt) |=> $stable(cnt_q));

endmodule

// File: rtl/pmu_rd_mux.sv
module pmu_rd_mux
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [GLB_BITS-1:0]            glb_rd,
    input  logic [NUM_CTR-1:0][DATA_W-1:0] cnt_rd,
    input  logic [NUM_CTR-1:0][DATA_W-1:0] ctl_rd,
    output logic [DATA_W-1:0]              rdata
);

    logic [DATA_W-1:0] rd_d;

    always_comb begin
        rd_d = '0;
        if (addr == ADDR_W'(GLB_ADDR))
            rd_d = DATA_W'(glb_rd);
        for (int i = 0; i < NUM_CTR; i++) begin
            if (addr == ADDR_W'(CNT_BASE + i))
                rd_d = cnt_rd[i];
            if (addr == ADDR_W'(CTL_BASE + i))
                rd_d = ctl_rd[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd_d;
    end

endmodule

// File: rtl/pmu_counter_unit.sv
module pmu_counter_unit
    import pmu_pkg::*;
#(
    parameter int NUM_CTR = 6,
    parameter int CNT_W   = 32,
    parameter int SEL_W   = 8,
    parameter int NUM_EVT = 16,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [CNT_W-1:0]   reg_wdata,
    output logic [CNT_W-1:0]   reg_rdata,
    input  logic [NUM_EVT-1:0] evt_in,
    input  logic               cpu_user,
    input  logic               cpu_mark,
    output logic               ovf_irq
);

    logic                          glb_wr;
    logic                          count_stop;
    logic                          ovf_any;
    logic [GLB_BITS-1:0]           glb_rd;
    logic [NUM_CTR-1:0]            ovf_cond;
    logic [NUM_CTR-1:0]            cnt_msb;
    logic [NUM_CTR-1:0][CNT_W-1:0] cnt_rd;
    logic [NUM_CTR-1:0][CNT_W-1:0] ctl_rd;

    assign glb_wr  = reg_wr && (reg_addr == ADDR_W'(GLB_ADDR));
    assign ovf_any = |ovf_cond;

    pmu_bank_ctrl u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .glb_wr     (glb_wr),
        .glb_wdata  (reg_wdata[GLB_BITS-1:0]),
        .ovf_any    (ovf_any),
        .count_stop (count_stop),
        .ovf_irq    (ovf_irq),
        .glb_rd     (glb_rd)
    );

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(CNT_BASE + g);
        localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTL_BASE + g);
        logic wr_cnt, wr_ctl;
        assign wr_cnt = reg_wr && (reg_addr == A_CNT);
        assign wr_ctl = reg_wr && (reg_addr == A_CTL);
        assign cnt_msb[g] = cnt_rd[g][CNT_W-1];

        pmu_counter #(
            .CNT_W   (CNT_W),
            .SEL_W   (SEL_W),
            .NUM_EVT (NUM_EVT)
        ) u_ctr (
            .clk        (clk),
            .rst_n      (rst_n),
            .count_stop (count_stop),
            .cpu_user   (cpu_user),
            .cpu_mark   (cpu_mark),
            .evt_in     (evt_in),
            .wr_cnt     (wr_cnt),
            .wr_ctl     (wr_ctl),
            .wdata      (reg_wdata),
            .cnt_q      (cnt_rd[g]),
            .ctl_rd     (ctl_rd[g]),
            .ovf_cond   (ovf_cond[g])
        );
    end

    pmu_rd_mux #(
        .NUM_CTR (NUM_CTR),
        .DATA_W  (CNT_W),
        .ADDR_W  (ADDR_W)
    ) u_rd (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .glb_rd (glb_rd),
        .cnt_rd (cnt_rd),
        .ctl_rd (ctl_rd),
        .rdata  (reg_rdata)
    );

    // R10: an interrupt request needs some counter with bit 31 set
    a_r10_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> (cnt_msb != '0));

    // R1: reset leaves the interrupt low on the first cycle out of reset
    a_r1_irq_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !ovf_irq);

endmodule

// File: tb/tb_pmu_counter_unit.sv
module tb_pmu_counter_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] evt_in = '0;
    logic        cpu_user = 1'b0;
    logic        cpu_mark = 1'b0;
    logic        ovf_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pmu_counter_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .evt_in    (evt_in),
        .cpu_user  (cpu_user),
        .cpu_mark  (cpu_mark),
        .ovf_irq   (ovf_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic do_reset();
        rst_n = 1'b0; reg_wr = 1'b0; evt_in = '0; cpu_user = 1'b0; cpu_mark = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a; reg_wr = 1'b0;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic drive(input logic [15:0] mask, input int n);
        evt_in = mask;
        repeat (n) @(negedge clk);
        evt_in = '0;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd(4'd0, v);  check("R1 global", v, 32'h1);
        rd(4'd1, v);  check("R1 counter0", v, 32'h0);
        rd(4'd6, v);  check("R1 counter5", v, 32'h0);
        rd(4'd8, v);  check("R1 ctl0", v, 32'h1F);
        rd(4'd13, v); check("R1 ctl5", v, 32'h1F);
        check("R1 irq", {31'b0, ovf_irq}, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        do_reset();
        wr(4'd15, 32'hDEAD_BEEF);
        rd(4'd15, v); check("R2 unused addr 15", v, 32'h0);
        rd(4'd7, v);  check("R2 unused addr 7", v, 32'h0);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v);  check("R2 global bits", v, 32'h7);
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, v);  check("R2 ctl1 bits", v, 32'h0000_FF3F);
        wr(4'd3, 32'h1234_5678);
        rd(4'd3, v);  check("R2 counter2 rw", v, 32'h1234_5678);
    endtask

    task automatic t_count_select();
        logic [31:0] v;
        do_reset();
        wr(4'd8, 32'h0300);
        wr(4'd9, 32'h0500);
        wr(4'd10, 32'hC800);
        wr(4'd0, 32'h0);
        drive(16'h0008, 7);
        rd(4'd1, v); check("R3 count 7 events", v, 32'd7);
        rd(4'd2, v); check("R4 other line ignored", v, 32'd0);
        drive(16'hFFFF, 4);
        rd(4'd1, v); check("R3 count all-high", v, 32'd11);
        rd(4'd2, v); check("R3 select 5", v, 32'd4);
        rd(4'd3, v); check("R4 select 200 never counts", v, 32'd0);
    endtask

    task automatic t_freezes();
        logic [31:0] v;
        do_reset();
        wr(4'd8, 32'h0300);
        wr(4'd9, 32'h0301);
        drive(16'h0008, 5);
        rd(4'd1, v); check("R5 global freeze", v, 32'd0);
        wr(4'd0, 32'h0);
        drive(16'h0008, 5);
        rd(4'd1, v); check("R6 neighbour counts", v, 32'd5);
        rd(4'd2, v); check("R6 own freeze", v, 32'd0);
        wr(4'd0, 32'h1);
        drive(16'h0008, 3);
        rd(4'd1, v); check("R5 refreeze", v, 32'd5);
    endtask

    task automatic t_priv_mark();
        logic [31:0] v;
        do_reset();
        wr(4'd8, 32'h0304);
        wr(4'd9, 32'h0302);
        wr(4'd10, 32'h0308);
        wr(4'd11, 32'h0310);
        wr(4'd0, 32'h0);
        cpu_user = 1'b1; cpu_mark = 1'b1;
        drive(16'h0008, 4);
        cpu_user = 1'b0; cpu_mark = 1'b0;
        drive(16'h0008, 3);
        rd(4'd1, v); check("R7 user freeze", v, 32'd3);
        rd(4'd2, v); check("R7 supervisor freeze", v, 32'd4);
        rd(4'd3, v); check("R8 mark-set freeze", v, 32'd3);
        rd(4'd4, v); check("R8 mark-clear freeze", v, 32'd4);
    endtask

    task automatic t_write_priority();
        logic [31:0] v;
        do_reset();
        wr(4'd8, 32'h0300);
        wr(4'd0, 32'h0);
        evt_in = 16'h0008;
        @(negedge clk);
        wr(4'd1, 32'h100);
        rd(4'd1, v);
        evt_in = '0;
        check("R9 write beats increment", v, 32'h100);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        do_reset();
        wr(4'd1, 32'h7FFF_FFFE);
        wr(4'd8, 32'h0320);
        wr(4'd0, 32'h2);
        drive(16'h0008, 1);
        check("R10 no irq below bit31", {31'b0, ovf_irq}, 32'h0);
        drive(16'h0008, 1);
        check("R10 irq on bit31", {31'b0, ovf_irq}, 32'h1);
        repeat (3) @(negedge clk);
        check("R10 irq level", {31'b0, ovf_irq}, 32'h1);
        wr(4'd1, 32'h5);
        check("R10 irq clears on rewrite", {31'b0, ovf_irq}, 32'h0);
        wr(4'd1, 32'h7FFF_FFFF);
        drive(16'h0008, 1);
        check("R10 irq again", {31'b0, ovf_irq}, 32'h1);
        wr(4'd0, 32'h0);
        check("R10 irq clears on disable", {31'b0, ovf_irq}, 32'h0);
        rd(4'd1, v); check("R10 counter past bit31", v, 32'h8000_0000);
    endtask

    task automatic t_auto_freeze();
        logic [31:0] v;
        do_reset();
        wr(4'd1, 32'h7FFF_FFFF);
        wr(4'd8, 32'h0320);
        wr(4'd10, 32'h0300);
        wr(4'd0, 32'h4);
        drive(16'h0008, 5);
        rd(4'd1, v); check("R11 overflowing counter stops", v, 32'h8000_0000);
        rd(4'd3, v); check("R11 whole bank stops", v, 32'd1);
        rd(4'd0, v); check("R11 freeze bit set", v, 32'h5);
        check("R11 no irq without enable", {31'b0, ovf_irq}, 32'h0);
        wr(4'd1, 32'h0);
        drive(16'h0008, 2);
        rd(4'd3, v); check("R11 stays frozen", v, 32'd1);
        wr(4'd0, 32'h4);
        drive(16'h0008, 2);
        rd(4'd3, v); check("R11 resumes after write", v, 32'd3);
    endtask

    task automatic t_no_cond();
        logic [31:0] v;
        do_reset();
        wr(4'd1, 32'h7FFF_FFFF);
        wr(4'd8, 32'h0300);
        wr(4'd0, 32'h6);
        drive(16'h0008, 3);
        check("R12 no irq", {31'b0, ovf_irq}, 32'h0);
        rd(4'd1, v); check("R12 no freeze", v, 32'h8000_0002);
        rd(4'd0, v); check("R12 global unchanged", v, 32'h6);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_map();
        t_count_select();
        t_freezes();
        t_priv_mark();
        t_write_priority();
        t_irq();
        t_auto_freeze();
        t_no_cond();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule